// File: doc/BRIEF.md
# Banked Priority Interrupt Controller

This controller gathers interrupt requests from one or more banks of 32 lines each and presents them to a processor on two request outputs: a normal one and a fast one. Each line has its own configuration: a 5-bit urgency value, a choice between edge and level detection, and a choice of output. Lines latch into a per-bank pending register and pass a per-bank mask before they take part in arbitration.

Each output carries a re-arm flag. When the flag is set and an unmasked pending line is routed to that output, the controller picks the winning line and latches its global number as the output's source code. It then clears the flag and raises the output. The output stays high until software writes the control register. Software reads the source code to learn which line won. That read also acknowledges an edge-type line. Software then writes the control register to drop the output and re-arm it. A software-set register lets firmware raise a request on any line.

Access is through a simple single-cycle register bus. Address bits above bit 7 pick the bank and the low byte picks the register. Read data is registered and is valid in the cycle after the read strobe.

Top module: `intc_banked`

## Requirements
- R1: After reset every mask bit is 1 and the pending, sensitivity, routing and urgency fields are all 0. Both outputs are low and both re-arm flags are set.
- R2: The line configuration word of line i is at offset 0x1C+4*i. It packs urgency in bits [6:2], sensitivity in bit 1 (1 = level, 0 = edge) and routing in bit 0 (1 = fast output, 0 = normal output). A read returns the same packing with all other bits 0.
- R3: A rising input sets the line's pending bit (pending at offset 0x00). An input held high does not set it again after it is cleared.
- R4: When the input of a level line falls, its pending bit clears. An edge line's pending bit is not cleared by a falling input.
- R5: A write to the pending register clears each bit written as 0. The exception is a level line whose input is currently high, which stays pending.
- R6: A write to the software-set register (offset 0x9C) sets the pending bit of only the lowest-numbered 1 bit of the written value, in that bank.
- R7: An output rises only when its re-arm flag is set and at least one unmasked pending line is routed to it. The mask is at offset 0x04 and a mask bit of 1 blocks its line. Once high, the output stays high until re-armed, even if nothing remains pending.
- R8: Urgency 0 is the most urgent. On a tie, the line with the higher global number (32*bank + line) wins.
- R9: A read of the normal code (offset 0x10) or the fast code (offset 0x14) returns the latched winner's line index within its bank (0..31). If that line is edge-sensitive, the read clears its pending bit. A level line stays pending.
- R10: Writing control (offset 0x18) with bit 0 set drops the normal output at once and sets its re-arm flag. Bit 1 does the same for the fast output. The output is evaluated again on the next cycle.
- R11: Control and the code registers respond only in bank 0. In other banks they read 0 and writes have no effect. Unmapped offsets read 0 and ignore writes.
- R12: A line routed to the fast output never raises the normal output, and a line routed to the normal output never raises the fast one.
- R13: Address bits above bit 7 select the bank, and each bank keeps its own pending, mask and configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_BANKS*32 | Request inputs, global line g at bit g |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8+BANK_W | Bank in the upper bits, register offset in bits [7:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The main sweep configures all 64 lines of two banks with several urgency patterns, including all-equal urgency. It sets a pending pattern, then drains it one acknowledge at a time and compares each code with an arithmetic model. A design with a reversed tie-break, or one that ignores the upper bank, would give the wrong drain order. Other focused sequences check the following:
- A level line must survive both a pending-clear write and a code read. A design that cleared it would lose a live request.
- A code or control access to bank 1 must have no effect. A design without a bank gate would acknowledge the wrong line or drop the fast output.
- An output must stay high after its last pending line is gone. A design that follows pending directly would drop the output early and break the handshake.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES  = 32;
    localparam int PRIO_W = 5;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_PEND     = 8'h00;
    localparam logic [7:0] OFS_MASK     = 8'h04;
    localparam logic [7:0] OFS_IRQ_CODE = 8'h10;
    localparam logic [7:0] OFS_FIQ_CODE = 8'h14;
    localparam logic [7:0] OFS_CTRL     = 8'h18;
    localparam logic [7:0] OFS_CFG_LO   = 8'h1C;
    localparam logic [7:0] OFS_CFG_HI   = 8'h98;
    localparam logic [7:0] OFS_SWSET    = 8'h9C;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [LINES-1:0][PRIO_W-1:0] prio_arr_t;

    typedef struct packed {
        line_vec_t pend;
        line_vec_t mask;
        line_vec_t sens;   // 1 = level
        line_vec_t route;  // 1 = fast output
        line_vec_t inp;    // last sampled inputs
        prio_arr_t prio;
    } bank_state_t;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N  = 64,
    parameter int PW = 5,
    parameter int IW = 6
) (
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio_flat,
    output logic            any,
    output logic [IW-1:0]   win
);
    logic [PW-1:0] best;

    // Ascending scan with <= : a later (higher-numbered) line wins a tie.
    always_comb begin
        any  = 1'b0;
        best = '1;
        win  = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!any || prio_flat[i*PW +: PW] <= best)) begin
                any  = 1'b1;
                best = prio_flat[i*PW +: PW];
                win  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  line_vec_t           line_in,
    input  logic                we,
    input  logic [7:0]          offs,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                ack_en,
    input  logic [4:0]          ack_idx,
    output logic [DATA_W-1:0]   rdata,
    output line_vec_t           pend_o,
    output line_vec_t           mask_o,
    output line_vec_t           route_o,
    output logic [LINES*PRIO_W-1:0] prio_o
);
    bank_state_t st_q, st_d;
    line_vec_t   rise, fall, setv, clrv;
    logic        cfg_hit;
    logic [7:0]  cfg_rel;
    logic [4:0]  cfg_idx;

    assign cfg_hit = (offs >= OFS_CFG_LO) && (offs <= OFS_CFG_HI) && (offs[1:0] == 2'b00);
    assign cfg_rel = offs - OFS_CFG_LO;
    assign cfg_idx = cfg_rel[6:2];
    assign rise    = line_in & ~st_q.inp;
    assign fall    = st_q.inp & ~line_in;

    always_comb begin
        st_d     = st_q;
        st_d.inp = line_in;
        setv     = rise;
        clrv     = fall & st_q.sens;
        if (ack_en && !st_q.sens[ack_idx])
            clrv[ack_idx] = 1'b1;
        if (we) begin
            if (offs == OFS_PEND)
                clrv = clrv | (~wdata & ~(st_q.sens & line_in));
            else if (offs == OFS_MASK)
                st_d.mask = wdata;
            else if (offs == OFS_SWSET)
                setv = setv | (wdata & (~wdata + 32'd1));
            else if (cfg_hit) begin
                st_d.prio[cfg_idx]  = wdata[6:2];
                st_d.sens[cfg_idx]  = wdata[1];
                st_d.route[cfg_idx] = wdata[0];
            end
        end
        st_d.pend = (st_q.pend & ~clrv) | setv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (offs == OFS_PEND)
            rdata = st_q.pend;
        else if (offs == OFS_MASK)
            rdata = st_q.mask;
        else if (cfg_hit)
            rdata = {25'd0, st_q.prio[cfg_idx], st_q.sens[cfg_idx], st_q.route[cfg_idx]};
    end

    assign pend_o  = st_q.pend;
    assign mask_o  = st_q.mask;
    assign route_o = st_q.route;
    assign prio_o  = st_q.prio;

    // R3: a rising input is pending after the edge
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(rise)) == $past(rise)));

    // R5: a level line with its input high survives a pending-clear write
    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (we && offs == OFS_PEND) |=>
        ((st_q.pend & $past(st_q.sens & line_in & st_q.pend)) == $past(st_q.sens & line_in & st_q.pend)));
endmodule

// File: rtl/intc_banked.sv
module intc_banked
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = 8 + BANK_W,
    localparam int NL       = NUM_BANKS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NL-1:0]     irq_lines,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int CW = BANK_W + 5;

    typedef struct packed {
        logic [1:0]         agr;
        logic [1:0]         out;
        logic [1:0][CW-1:0] code;
        logic [31:0]        rdata;
    } top_state_t;

    top_state_t q, d;

    logic [7:0]        offs;
    logic [BANK_W-1:0] abank;
    logic              rd_code, rd_irq_code, ctrl_wr;
    logic [CW-1:0]     ack_code;
    logic [NUM_BANKS-1:0] hit;
    logic [31:0]       bank_rd [NUM_BANKS];
    logic [NL-1:0]     pend_all, mask_all, route_all;
    logic [NL*PRIO_W-1:0] prio_all;
    logic [1:0][NL-1:0]   elig;
    logic [1:0]           any;
    logic [1:0][CW-1:0]   win;

    assign offs        = bus_addr[7:0];
    assign abank       = bus_addr[ADDR_W-1:8];
    assign rd_irq_code = bus_sel && !bus_wr && hit[0] && offs == OFS_IRQ_CODE;
    assign rd_code     = rd_irq_code || (bus_sel && !bus_wr && hit[0] && offs == OFS_FIQ_CODE);
    assign ctrl_wr     = bus_sel && bus_wr && hit[0] && offs == OFS_CTRL;
    assign ack_code    = rd_irq_code ? q.code[0] : q.code[1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit[b] = (abank == BANK_W'(b));
        intc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (irq_lines[b*LINES +: LINES]),
            .we      (bus_sel && bus_wr && hit[b]),
            .offs    (offs),
            .wdata   (bus_wdata),
            .ack_en  (rd_code && ack_code[CW-1:5] == BANK_W'(b)),
            .ack_idx (ack_code[4:0]),
            .rdata   (bank_rd[b]),
            .pend_o  (pend_all[b*LINES +: LINES]),
            .mask_o  (mask_all[b*LINES +: LINES]),
            .route_o (route_all[b*LINES +: LINES]),
            .prio_o  (prio_all[b*LINES*PRIO_W +: LINES*PRIO_W])
        );
    end

    assign elig[0] = pend_all & ~mask_all & ~route_all;
    assign elig[1] = pend_all & ~mask_all & route_all;

    for (genvar k = 0; k < 2; k++) begin : g_arb
        intc_arbiter #(.N(NL), .PW(PRIO_W), .IW(CW)) u_arb (
            .elig      (elig[k]),
            .prio_flat (prio_all),
            .any       (any[k]),
            .win       (win[k])
        );
    end

    always_comb begin
        d = q;
        for (int k = 0; k < 2; k++) begin
            if (q.agr[k] && any[k]) begin
                d.agr[k]  = 1'b0;
                d.out[k]  = 1'b1;
                d.code[k] = win[k];
            end
            if (ctrl_wr && bus_wdata[k]) begin
                d.agr[k] = 1'b1;
                d.out[k] = 1'b0;
            end
        end
        if (bus_sel && !bus_wr) begin
            d.rdata = '0;
            if (hit[0] && offs == OFS_IRQ_CODE)
                d.rdata = {27'd0, q.code[0][4:0]};
            else if (hit[0] && offs == OFS_FIQ_CODE)
                d.rdata = {27'd0, q.code[1][4:0]};
            else if (offs != OFS_CTRL && offs != OFS_IRQ_CODE && offs != OFS_FIQ_CODE) begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (hit[b]) d.rdata = bank_rd[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.agr <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq_o     = q.out[0];
    assign fiq_o     = q.out[1];

    // R7: normal output rises only from an armed flag and an eligible line
    a_r7_irq_rise_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(q.agr[0]) && $past(any[0])));

    // R12: fast output rises only from an armed flag and a fast-routed line
    a_r12_fiq_rise_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> ($past(q.agr[1]) && $past(any[1])));

    // R8: the arbiter's winner is an eligible line
    a_r8_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        any[0] |-> elig[0][win[0]]);

    // R10: a control write with bit 0 drops the normal output
    a_r10_ctrl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0]) |=> !irq_o);
endmodule

// File: tb/intc_banked_test.sv
module intc_banked_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] lines;
    logic        bus_sel, bus_wr;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_o, fiq_o;
    int          tests = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    intc_banked #(.NUM_BANKS(2)) uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [8:0] ad(input int b, input int off);
        return 9'(b * 256 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int prio_of(input int pat, input int g);
        case (pat)
            0: return 0;
            1: return (g * 7 + 3) % 32;
            2: return g % 3;
            default: return (g * 13) % 32;
        endcase
    endfunction

    // R8 / R9 sweep: load a pattern, drain it one acknowledge at a time
    task automatic run_pattern(input int pat, input logic [63:0] setv);
        logic [63:0] rem;
        logic [31:0] v;
        int best, bp;
        lines = '0;
        for (int g = 0; g < 64; g++)
            wr(ad(g / 32, 'h1C + 4 * (g % 32)), 32'(prio_of(pat, g) << 2));
        wr(ad(0, 'h00), 0); wr(ad(1, 'h00), 0);
        wr(ad(0, 'h04), 0); wr(ad(1, 'h04), 0);
        for (int g = 0; g < 64; g++)
            if (setv[g]) wr(ad(g / 32, 'h9C), 32'd1 << (g % 32));
        rem = setv;
        while (rem != 0) begin
            best = -1; bp = 99;
            for (int g = 0; g < 64; g++)
                if (rem[g] && prio_of(pat, g) <= bp) begin
                    bp = prio_of(pat, g); best = g;
                end
            wr(ad(0, 'h18), 1);
            idle(2);
            chk("R7 irq raised in sweep", 32'(irq_o), 1);
            rd(ad(0, 'h10), v);
            chk("R8 winner code", v, 32'(best % 32));
            rem[best] = 1'b0;
        end
        wr(ad(0, 'h18), 1);
        idle(2);
        chk("R7 irq idle after drain", 32'(irq_o), 0);
        rd(ad(0, 'h00), v); chk("R9 bank0 drained", v, 0);
        rd(ad(1, 'h00), v); chk("R9 bank1 drained", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; lines = '0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(ad(0, 'h04), v); chk("R1 mask b0", v, 32'hFFFF_FFFF);
        rd(ad(1, 'h04), v); chk("R1 mask b1", v, 32'hFFFF_FFFF);
        rd(ad(0, 'h00), v); chk("R1 pending b0", v, 0);
        rd(ad(1, 'h98), v); chk("R1 cfg b1 line31", v, 0);
        chk("R1 irq low", 32'(irq_o), 0);
        chk("R1 fiq low", 32'(fiq_o), 0);

        // R2 / R13 configuration packing and bank separation
        wr(ad(1, 'h1C + 4 * 5), 32'hFFFF_FF57);
        rd(ad(1, 'h1C + 4 * 5), v); chk("R2 cfg packing", v, 32'h57);
        rd(ad(0, 'h1C + 4 * 5), v); chk("R13 other bank untouched", v, 0);
        wr(ad(1, 'h1C + 4 * 5), 0);

        // R6 software set, lowest bit only
        wr(ad(0, 'h9C), 32'h0000_00A0);
        rd(ad(0, 'h00), v); chk("R6 lowest bit only", v, 32'h20);
        rd(ad(1, 'h00), v); chk("R13 bank1 pending clear", v, 0);
        wr(ad(0, 'h00), 0);
        rd(ad(0, 'h00), v); chk("R5 clear edge line", v, 0);

        // R3 edge detection
        lines[3] = 1'b1; idle(2);
        rd(ad(0, 'h00), v); chk("R3 rise sets", v, 32'h8);
        wr(ad(0, 'h00), 0); idle(3);
        rd(ad(0, 'h00), v); chk("R3 held high no re-set", v, 0);
        lines[3] = 1'b0; idle(2);
        lines[3] = 1'b1; idle(2);
        rd(ad(0, 'h00), v); chk("R3 second rise sets", v, 32'h8);
        lines[3] = 1'b0; idle(2);
        rd(ad(0, 'h00), v); chk("R4 edge line not cleared by fall", v, 32'h8);

        // R4 / R5 level line
        wr(ad(0, 'h1C + 4 * 4), 32'h2);
        lines[4] = 1'b1; idle(2);
        rd(ad(0, 'h00), v); chk("R3 level rise sets", v, 32'h18);
        wr(ad(0, 'h00), 0);
        rd(ad(0, 'h00), v); chk("R5 level high survives clear", v, 32'h10);
        lines[4] = 1'b0; idle(2);
        rd(ad(0, 'h00), v); chk("R4 level fall clears", v, 0);

        // R7 / R9 / R10 handshake
        wr(ad(0, 'h9C), 32'h8); idle(3);
        chk("R7 masked no output", 32'(irq_o), 0);
        wr(ad(0, 'h04), 32'hFFFF_FFF7); idle(2);
        chk("R7 unmasked raises irq", 32'(irq_o), 1);
        rd(ad(0, 'h10), v); chk("R9 irq code", v, 3);
        rd(ad(0, 'h00), v); chk("R9 edge acked", v, 0);
        idle(2);
        chk("R7 output held without pending", 32'(irq_o), 1);
        wr(ad(0, 'h1C + 4 * 6), 32'h2);
        wr(ad(0, 'h04), 32'hFFFF_FFB7);
        lines[6] = 1'b1; idle(2);
        wr(ad(0, 'h18), 1);
        chk("R10 control drops irq", 32'(irq_o), 0);
        idle(2);
        chk("R10 re-evaluated", 32'(irq_o), 1);
        rd(ad(0, 'h10), v); chk("R9 level code", v, 6);
        rd(ad(0, 'h00), v); chk("R9 level not acked", v, 32'h40);
        lines[6] = 1'b0; idle(2);
        wr(ad(0, 'h18), 1); idle(2);
        chk("R10 nothing pending stays low", 32'(irq_o), 0);

        // R11 / R12 fast output and bank-0 gating
        wr(ad(1, 'h1C + 4 * 9), 32'h1);
        wr(ad(1, 'h9C), 32'h200);
        wr(ad(1, 'h04), 0); idle(2);
        chk("R12 fiq raised", 32'(fiq_o), 1);
        chk("R12 irq not raised", 32'(irq_o), 0);
        rd(ad(1, 'h14), v); chk("R11 bank1 code reads 0", v, 0);
        rd(ad(1, 'h00), v); chk("R11 bank1 code read no ack", v, 32'h200);
        wr(ad(1, 'h18), 3); idle(1);
        chk("R11 bank1 control ignored", 32'(fiq_o), 1);
        rd(ad(0, 'h14), v); chk("R9 fiq code", v, 9);
        rd(ad(1, 'h00), v); chk("R9 fiq ack clears bank1", v, 0);
        rd(ad(0, 'h0C), v); chk("R11 unmapped reads 0", v, 0);
        wr(ad(0, 'h0C), 32'hFFFF_FFFF);
        rd(ad(0, 'h04), v); chk("R11 unmapped write ignored", v, 32'hFFFF_FFB7);
        wr(ad(0, 'h18), 2);
        chk("R10 control drops fiq", 32'(fiq_o), 0);
        idle(2);
        chk("R10 fiq stays low", 32'(fiq_o), 0);

        // R8 sweeps over both banks
        run_pattern(0, 64'hFFFF_FFFF_FFFF_FFFF);
        run_pattern(1, 64'hFFFF_FFFF_FFFF_FFFF);
        run_pattern(2, 64'hF0F0_0F0F_1234_8001);
        run_pattern(3, 64'h8000_0001_C000_0003);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule